// File: doc/BRIEF.md
# Regional Triggered Hit Store

This block keeps the hits of four neighbouring pixel cells in a small shared pool of slots. It holds each hit until the trigger latency has passed. A pixel hit is the rising edge of that pixel's discriminator. The slot records the crossing number of that edge. It also counts how many crossings the discriminator stays high, which gives the time over threshold. When several pixels of the region rise in the same crossing, they share one slot, and a mask shows which pixels were hit.

Each slot is judged once, in the crossing where its stamp plus the programmed latency equals the current crossing counter. If the trigger strobe is high in that crossing, the slot is queued for the end of column. Otherwise it is erased on the spot, which is the fate of nearly every stored hit. Queued slots leave through a valid/ready handshake in the order they were queued. A slot is freed when its data is accepted. A hit that finds every slot taken is lost and counted.

Top module: `hitmem_region`

## Requirements
- R1: After reset no slot is held, `eoc_valid` is 0 and `loss_count` is 0.
- R2: A rising edge on any bit of `pix_disc` takes the lowest-numbered free slot and records `bx_cnt` as its stamp. All pixels that rise in the same crossing share that slot, and bit p of the mask stands for pixel p.
- R3: The time-over-threshold nibble of pixel p sits in bits [4p+3:4p] of `eoc_tot`. It counts the crossings in which the discriminator is high, starting with the rising crossing, and it saturates at 15. A pixel outside the mask reads 0.
- R4: A slot is judged in the crossing where `bx_cnt` equals (stamp + `latency`) modulo 2^BX_W. If `trig` is high in that crossing, the slot appears on the readout port in the next crossing. If `trig` is low, the slot is erased. A trigger in any other crossing has no effect on that slot.
- R5: The latency comes from the `latency` input, in crossings, with a useful range of 1 to 240. It must stay constant while hits are stored.
- R6: A hit that finds no free slot is dropped, and `loss_count` rises by one. The count saturates at its all-ones value.
- R7: A slot freed in a crossing can only be taken by a hit in the next crossing. A hit in the freeing crossing itself is dropped if the pool was full.
- R8: While `eoc_valid` is high and `eoc_ready` is low, the stamp, mask and amplitudes on the port do not change. A transfer completes on a crossing with both high, and that slot is freed.
- R9: Queued slots leave oldest first, in the order of their stamps.
- R10: The number of slots is the parameter N_SLOTS, with a default of 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock, one crossing per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_disc | input | 4 | Discriminator level of each of the four pixels |
| bx_cnt | input | BX_W | Current crossing number |
| latency | input | BX_W | Trigger latency in crossings |
| trig | input | 1 | Trigger strobe for the crossing now being judged |
| eoc_ready | input | 1 | End of column accepts the offered hit |
| eoc_valid | output | 1 | A triggered hit is offered |
| eoc_stamp | output | BX_W | Crossing stamp of the offered hit |
| eoc_mask | output | 4 | Pixels hit in the offered slot |
| eoc_tot | output | 16 | Four 4-bit time-over-threshold values |
| loss_count | output | LOSS_W | Saturating count of dropped hits |

## Verification
Two functions can fall in the same cycle: the judgement that erases an old slot, and the arrival of a new hit while the pool is still full. The bench fills all five slots, then places one hit exactly on the judgement crossing of the oldest slot with the trigger low, and a second hit one crossing later. The first hit must raise the loss count, and the second must land in the freed slot and later come out with its own stamp. A second overlap, a trigger judgement in the same crossing as a readout hold, is covered by queuing two slots back to back while `eoc_ready` is low and checking the order in which they drain.

// File: rtl/hitmem_pkg.sv
`timescale 1ns/1ps
package hitmem_pkg;
  localparam int NPIX  = 4;
  localparam int TOT_W = 4;

  typedef enum logic [1:0] {
    SLOT_FREE   = 2'd0,
    SLOT_WAIT   = 2'd1,
    SLOT_QUEUED = 2'd2
  } slot_state_e;

  // saturating increment of one amplitude nibble
  function automatic logic [TOT_W-1:0] tot_step(input logic [TOT_W-1:0] cur);
    return (cur == {TOT_W{1'b1}}) ? cur : cur + 1'b1;
  endfunction

  // initial amplitudes: one crossing for every pixel that rose
  function automatic logic [NPIX*TOT_W-1:0] tot_seed(input logic [NPIX-1:0] m);
    logic [NPIX*TOT_W-1:0] r;
    r = '0;
    for (int p = 0; p < NPIX; p++) begin
      if (m[p]) r[p*TOT_W +: TOT_W] = TOT_W'(1);
    end
    return r;
  endfunction
endpackage

// File: rtl/hitmem_pix_edge.sv
`timescale 1ns/1ps
module hitmem_pix_edge
  import hitmem_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIX-1:0] disc,
  output logic [NPIX-1:0] rise
);
  logic [NPIX-1:0] disc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) disc_q <= '0;
    else        disc_q <= disc;
  end

  assign rise = disc & ~disc_q;
endmodule

// File: rtl/hitmem_slot.sv
`timescale 1ns/1ps
module hitmem_slot
  import hitmem_pkg::*;
#(
  parameter int BX_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc,
  input  logic [BX_W-1:0]        alloc_stamp,
  input  logic [NPIX-1:0]        alloc_mask,
  input  logic [NPIX-1:0]        tot_inc,
  input  logic [BX_W-1:0]        bx,
  input  logic [BX_W-1:0]        latency,
  input  logic                   trig,
  input  logic                   release_i,
  output slot_state_e            state,
  output logic [BX_W-1:0]        stamp,
  output logic [NPIX-1:0]        mask,
  output logic [NPIX*TOT_W-1:0]  tot,
  output logic                   due_hit,
  output logic                   due_miss
);
  slot_state_e            state_q;
  logic [BX_W-1:0]        stamp_q;
  logic [NPIX-1:0]        mask_q;
  logic [NPIX*TOT_W-1:0]  tot_q;
  logic                   due;

  // judgement crossing: stamp plus latency, modulo the counter range
  function automatic logic deadline_due(input logic [BX_W-1:0] st,
                                        input logic [BX_W-1:0] lat,
                                        input logic [BX_W-1:0] now);
    logic [BX_W-1:0] sum;
    sum = st + lat;
    return sum == now;
  endfunction

  assign due      = (state_q == SLOT_WAIT) && deadline_due(stamp_q, latency, bx);
  assign due_hit  = due && trig;
  assign due_miss = due && !trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SLOT_FREE;
      stamp_q <= '0;
      mask_q  <= '0;
      tot_q   <= '0;
    end else begin
      unique case (state_q)
        SLOT_FREE: begin
          if (alloc) begin
            state_q <= SLOT_WAIT;
            stamp_q <= alloc_stamp;
            mask_q  <= alloc_mask;
            tot_q   <= tot_seed(alloc_mask);
          end
        end
        SLOT_WAIT: begin
          for (int p = 0; p < NPIX; p++) begin
            if (tot_inc[p]) tot_q[p*TOT_W +: TOT_W] <= tot_step(tot_q[p*TOT_W +: TOT_W]);
          end
          if (due) state_q <= trig ? SLOT_QUEUED : SLOT_FREE;
        end
        SLOT_QUEUED: begin
          if (release_i) state_q <= SLOT_FREE;
        end
        default: state_q <= SLOT_FREE;
      endcase
    end
  end

  assign state = state_q;
  assign stamp = stamp_q;
  assign mask  = mask_q;
  assign tot   = tot_q;
endmodule

// File: rtl/hitmem_order_fifo.sv
`timescale 1ns/1ps
module hitmem_order_fifo #(
  parameter int DEPTH = 5,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop,
  output logic [IDX_W-1:0] head_idx,
  output logic             nonempty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [IDX_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= ptr_next(wr_q);
      if (pop)  rd_q <= ptr_next(rd_q);
      cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign head_idx = mem[rd_q];
  assign nonempty = (cnt_q != '0);
endmodule

// File: rtl/hitmem_region.sv
`timescale 1ns/1ps
module hitmem_region
  import hitmem_pkg::*;
#(
  parameter int N_SLOTS = 5,
  parameter int BX_W    = 8,
  parameter int LOSS_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPIX-1:0]       pix_disc,
  input  logic [BX_W-1:0]       bx_cnt,
  input  logic [BX_W-1:0]       latency,
  input  logic                  trig,
  input  logic                  eoc_ready,
  output logic                  eoc_valid,
  output logic [BX_W-1:0]       eoc_stamp,
  output logic [NPIX-1:0]       eoc_mask,
  output logic [NPIX*TOT_W-1:0] eoc_tot,
  output logic [LOSS_W-1:0]     loss_count
);
  localparam int IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;
  localparam int NPOW  = 1 << IDX_W;

  // named internal events, brought out for the checker
  logic [NPIX-1:0]    rise;
  logic               hit_evt;
  logic               pool_full;
  logic               alloc_evt;
  logic               drop_evt;
  logic               pop_evt;
  logic [N_SLOTS-1:0] free_vec;
  logic [N_SLOTS-1:0] alloc_vec;
  logic [N_SLOTS-1:0] resolve_hit_vec;
  logic [N_SLOTS-1:0] resolve_miss_vec;
  logic [N_SLOTS-1:0] release_vec;
  logic [NPOW-1:0]    decided_pad;
  logic [IDX_W-1:0]   alloc_idx;
  logic [IDX_W-1:0]   push_idx;
  logic [IDX_W-1:0]   head_idx;
  logic               queue_nonempty;

  slot_state_e           slot_state [N_SLOTS];
  logic [BX_W-1:0]       slot_stamp [N_SLOTS];
  logic [NPIX-1:0]       slot_mask  [N_SLOTS];
  logic [NPIX*TOT_W-1:0] slot_tot   [N_SLOTS];
  logic [NPIX-1:0]       slot_inc   [N_SLOTS];

  logic [NPIX-1:0]       active_q;
  logic [IDX_W-1:0]      owner_q [NPIX];
  logic [LOSS_W-1:0]     loss_q;

  // isolate the lowest set bit: the lowest-numbered free slot wins
  function automatic logic [N_SLOTS-1:0] lowest_one(input logic [N_SLOTS-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  function automatic logic [IDX_W-1:0] onehot_idx(input logic [N_SLOTS-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (v[i]) r = r | IDX_W'(i);
    end
    return r;
  endfunction

  function automatic logic [LOSS_W-1:0] sat_inc(input logic [LOSS_W-1:0] c);
    return (c == {LOSS_W{1'b1}}) ? c : c + 1'b1;
  endfunction

  hitmem_pix_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .disc (pix_disc),
    .rise (rise)
  );

  assign hit_evt   = |rise;
  assign pool_full = ~|free_vec;
  assign alloc_evt = hit_evt && !pool_full;
  assign drop_evt  = hit_evt && pool_full;
  assign alloc_vec = alloc_evt ? lowest_one(free_vec) : '0;
  assign alloc_idx = onehot_idx(alloc_vec);

  assign pop_evt     = eoc_valid && eoc_ready;
  assign release_vec = pop_evt ? (N_SLOTS'(1) << head_idx) : '0;
  assign decided_pad = NPOW'(resolve_hit_vec | resolve_miss_vec);

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    for (genvar p = 0; p < NPIX; p++) begin : g_inc
      assign slot_inc[s][p] = active_q[p] && (owner_q[p] == IDX_W'(s)) && pix_disc[p];
    end

    hitmem_slot #(.BX_W(BX_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc      (alloc_vec[s]),
      .alloc_stamp(bx_cnt),
      .alloc_mask (rise),
      .tot_inc    (slot_inc[s]),
      .bx         (bx_cnt),
      .latency    (latency),
      .trig       (trig),
      .release_i  (release_vec[s]),
      .state      (slot_state[s]),
      .stamp      (slot_stamp[s]),
      .mask       (slot_mask[s]),
      .tot        (slot_tot[s]),
      .due_hit    (resolve_hit_vec[s]),
      .due_miss   (resolve_miss_vec[s])
    );

    assign free_vec[s] = (slot_state[s] == SLOT_FREE);
  end

  // which slot each pixel's ongoing pulse belongs to
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
      for (int p = 0; p < NPIX; p++) owner_q[p] <= '0;
    end else begin
      for (int p = 0; p < NPIX; p++) begin
        if (rise[p] && alloc_evt) begin
          active_q[p] <= 1'b1;
          owner_q[p]  <= alloc_idx;
        end else if (!pix_disc[p] || decided_pad[owner_q[p]]) begin
          active_q[p] <= 1'b0;
        end
      end
    end
  end

  // at most one slot is judged per crossing, so one push per cycle
  assign push_idx = onehot_idx(resolve_hit_vec);

  hitmem_order_fifo #(.DEPTH(N_SLOTS), .IDX_W(IDX_W)) u_order (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (|resolve_hit_vec),
    .push_idx(push_idx),
    .pop     (pop_evt),
    .head_idx(head_idx),
    .nonempty(queue_nonempty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        loss_q <= '0;
    else if (drop_evt) loss_q <= sat_inc(loss_q);
  end

  assign eoc_valid  = queue_nonempty;
  assign eoc_stamp  = slot_stamp[head_idx];
  assign eoc_mask   = slot_mask[head_idx];
  assign eoc_tot    = slot_tot[head_idx];
  assign loss_count = loss_q;
endmodule

// File: rtl/hitmem_region_chk.sv
`timescale 1ns/1ps
module hitmem_region_chk
  import hitmem_pkg::*;
#(
  parameter int N_SLOTS = 5,
  parameter int BX_W    = 8,
  parameter int LOSS_W  = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  eoc_valid,
  input logic                  eoc_ready,
  input logic [BX_W-1:0]       eoc_stamp,
  input logic [NPIX-1:0]       eoc_mask,
  input logic [NPIX*TOT_W-1:0] eoc_tot,
  input logic [LOSS_W-1:0]     loss_count,
  input logic                  drop_evt,
  input logic [N_SLOTS-1:0]    alloc_vec,
  input logic [N_SLOTS-1:0]    resolve_hit_vec,
  input logic [N_SLOTS-1:0]    resolve_miss_vec
);
  function automatic logic tot_fits_mask(input logic [NPIX*TOT_W-1:0] t,
                                         input logic [NPIX-1:0] m);
    logic ok;
    ok = 1'b1;
    for (int p = 0; p < NPIX; p++) begin
      if ((t[p*TOT_W +: TOT_W] != '0) != m[p]) ok = 1'b0;
    end
    return ok;
  endfunction

  // R2: one slot taken per crossing at most
  a_r2_single_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_vec));

  // R4: stamps are unique, so at most one slot is judged per crossing
  a_r4_one_judgement: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(resolve_hit_vec | resolve_miss_vec));

  // R4: a triggered slot is offered in the next crossing
  a_r4_queue_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (|resolve_hit_vec) |=> eoc_valid);

  // R3: every masked pixel carries a nonzero amplitude, the others zero
  a_r3_tot_mask: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_valid |-> (eoc_mask != '0) && tot_fits_mask(eoc_tot, eoc_mask));

  // R6: a drop raises the counter by exactly one until it saturates
  a_r6_loss_step: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt && (loss_count != {LOSS_W{1'b1}})) |=> loss_count == $past(loss_count) + 1'b1);

  // R6: without a drop the counter does not move
  a_r6_loss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !drop_evt |=> $stable(loss_count));

  // R8: an offer is held unchanged until accepted
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc_valid && !eoc_ready) |=> eoc_valid && $stable(eoc_stamp) &&
                                  $stable(eoc_mask) && $stable(eoc_tot));
endmodule

bind hitmem_region hitmem_region_chk #(
  .N_SLOTS(N_SLOTS),
  .BX_W   (BX_W),
  .LOSS_W (LOSS_W)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .eoc_valid       (eoc_valid),
  .eoc_ready       (eoc_ready),
  .eoc_stamp       (eoc_stamp),
  .eoc_mask        (eoc_mask),
  .eoc_tot         (eoc_tot),
  .loss_count      (loss_count),
  .drop_evt        (drop_evt),
  .alloc_vec       (alloc_vec),
  .resolve_hit_vec (resolve_hit_vec),
  .resolve_miss_vec(resolve_miss_vec)
);

// File: tb/hitmem_region_tb.sv
`timescale 1ns/1ps
module hitmem_region_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  pix_disc = '0;
  logic [7:0]  bx_cnt = '0;
  logic [7:0]  latency = 8'd20;
  logic        trig = 1'b0;
  logic        eoc_ready = 1'b0;
  logic        eoc_valid;
  logic [7:0]  eoc_stamp;
  logic [3:0]  eoc_mask;
  logic [15:0] eoc_tot;
  logic [7:0]  loss_count;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  hitmem_region u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_disc  (pix_disc),
    .bx_cnt    (bx_cnt),
    .latency   (latency),
    .trig      (trig),
    .eoc_ready (eoc_ready),
    .eoc_valid (eoc_valid),
    .eoc_stamp (eoc_stamp),
    .eoc_mask  (eoc_mask),
    .eoc_tot   (eoc_tot),
    .loss_count(loss_count)
  );

  typedef struct packed {
    logic [3:0] mask;
    logic [7:0] dur;
    logic       trg;
  } vec_t;

  // single-pulse scenarios at latency 20: mask, crossings held high, trigger
  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{4'b0001, 8'd3,  1'b1},
    '{4'b1010, 8'd20, 1'b1},
    '{4'b1111, 8'd1,  1'b0},
    '{4'b0100, 8'd15, 1'b1},
    '{4'b0011, 8'd14, 1'b1},
    '{4'b1000, 8'd5,  1'b0}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one crossing: inputs set before this call apply at the coming edge
  task automatic cyc();
    @(negedge clk);
    bx_cnt = bx_cnt + 8'd1;
  endtask

  task automatic wait_bx(input logic [7:0] target);
    while (bx_cnt != target) cyc();
  endtask

  function automatic logic [15:0] exp_tot(input logic [3:0] m, input int d);
    logic [15:0] r;
    r = '0;
    for (int p = 0; p < 4; p++) begin
      if (m[p]) r[p*4 +: 4] = (d > 15) ? 4'd15 : 4'(d);
    end
    return r;
  endfunction

  task automatic pop_one();
    eoc_ready = 1'b1;
    cyc();
    eoc_ready = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    logic [7:0] b;
    b = bx_cnt;
    pix_disc = v.mask;
    repeat (int'(v.dur)) cyc();
    pix_disc = '0;
    wait_bx(8'(b + latency));
    trig = v.trg;
    cyc();
    trig = 1'b0;
    chk("R4", "valid after judgement", 32'(eoc_valid), 32'(v.trg));
    if (v.trg) begin
      chk("R2", "stamp", 32'(eoc_stamp), 32'(b));
      chk("R2", "mask", 32'(eoc_mask), 32'(v.mask));
      chk("R3", "tot", 32'(eoc_tot), 32'(exp_tot(v.mask, int'(v.dur))));
      pop_one();
      chk("R8", "valid after accept", 32'(eoc_valid), 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] b;
    int exp_loss;

    // R1: reset state
    repeat (3) cyc();
    chk("R1", "valid in reset", 32'(eoc_valid), 32'd0);
    rst_n = 1'b1;
    cyc();
    chk("R1", "valid after reset", 32'(eoc_valid), 32'd0);
    chk("R1", "loss after reset", 32'(loss_count), 32'd0);

    // table walk: R2 R3 R4
    latency = 8'd20;
    for (int i = 0; i < NVEC; i++) begin
      run_vec(VECS[i]);
      repeat (2) cyc();
    end

    // R4: a trigger one crossing early, none on time, gives nothing
    b = bx_cnt;
    pix_disc = 4'b0001;
    repeat (2) cyc();
    pix_disc = '0;
    wait_bx(8'(b + latency - 8'd1));
    trig = 1'b1;
    cyc();
    trig = 1'b0;
    chk("R4", "early trigger", 32'(eoc_valid), 32'd0);
    cyc();
    chk("R4", "no trigger at deadline", 32'(eoc_valid), 32'd0);
    repeat (3) cyc();

    // R3 R2 R9: per-pixel amplitudes, separate slots, oldest first
    b = bx_cnt;
    pix_disc = 4'b1001; cyc();
    pix_disc = 4'b1011; cyc();
    pix_disc = 4'b1000;
    repeat (5) cyc();
    pix_disc = 4'b0000;
    wait_bx(8'(b + latency));
    trig = 1'b1; cyc();
    cyc();
    trig = 1'b0;
    chk("R9", "first out stamp", 32'(eoc_stamp), 32'(b));
    chk("R2", "shared slot mask", 32'(eoc_mask), 32'h9);
    chk("R3", "per-pixel tot", 32'(eoc_tot), 32'h7002);
    pop_one();
    chk("R9", "second out stamp", 32'(eoc_stamp), 32'(8'(b + 8'd1)));
    chk("R2", "later rise own slot", 32'(eoc_mask), 32'h2);
    chk("R3", "short pulse tot", 32'(eoc_tot), 32'h0010);
    pop_one();
    chk("R8", "queue drained", 32'(eoc_valid), 32'd0);
    repeat (3) cyc();

    // R6 R7 R10: fill the five slots, overflow, collide with a judgement
    latency = 8'd40;
    b = bx_cnt;
    for (int k = 0; k < 5; k++) begin
      pix_disc = 4'b0001; cyc();
      pix_disc = 4'b0000; cyc();
    end
    pix_disc = 4'b0001; cyc();
    pix_disc = 4'b0000;
    chk("R10", "sixth hit dropped", 32'(loss_count), 32'd1);
    wait_bx(8'(b + 8'd40));
    pix_disc = 4'b0010; cyc();
    pix_disc = 4'b0100; cyc();
    pix_disc = 4'b0000;
    chk("R7", "hit on freeing crossing dropped", 32'(loss_count), 32'd2);
    wait_bx(8'(b + 8'd42));
    trig = 1'b1; cyc(); trig = 1'b0;
    wait_bx(8'(b + 8'd44));
    trig = 1'b1; cyc(); trig = 1'b0;
    chk("R9", "older of two", 32'(eoc_stamp), 32'(8'(b + 8'd2)));
    cyc();
    chk("R8", "held without ready", 32'(eoc_stamp), 32'(8'(b + 8'd2)));
    pop_one();
    chk("R9", "younger of two", 32'(eoc_stamp), 32'(8'(b + 8'd4)));
    pop_one();
    chk("R8", "both accepted", 32'(eoc_valid), 32'd0);
    wait_bx(8'(b + 8'd81));
    trig = 1'b1; cyc(); trig = 1'b0;
    chk("R7", "next-crossing hit stored", 32'(eoc_valid), 32'd1);
    chk("R7", "reused slot stamp", 32'(eoc_stamp), 32'(8'(b + 8'd41)));
    chk("R7", "reused slot mask", 32'(eoc_mask), 32'h4);
    chk("R3", "reused slot tot", 32'(eoc_tot), 32'h0100);
    pop_one();
    chk("R6", "loss unchanged by reuse", 32'(loss_count), 32'd2);
    repeat (3) cyc();

    // R5 R6: short latency, all slots queued and held, counter saturates
    latency = 8'd10;
    b = bx_cnt;
    for (int k = 0; k < 5; k++) begin
      pix_disc = 4'b0001; cyc();
      pix_disc = 4'b0000; cyc();
    end
    trig = 1'b1;
    wait_bx(8'(b + 8'd19));
    trig = 1'b0;
    chk("R5", "short latency offer", 32'(eoc_valid), 32'd1);
    chk("R5", "short latency stamp", 32'(eoc_stamp), 32'(b));
    exp_loss = 2;
    for (int k = 0; k < 300; k++) begin
      pix_disc = (k % 2 == 0) ? 4'b0001 : 4'b0010;
      cyc();
      exp_loss = (exp_loss < 255) ? exp_loss + 1 : 255;
    end
    pix_disc = 4'b0000;
    cyc();
    chk("R6", "loss saturated", 32'(loss_count), 32'(exp_loss));
    chk("R8", "offer held through drops", 32'(eoc_stamp), 32'(b));

    // R1: reset clears held data and counter
    rst_n = 1'b0;
    cyc();
    chk("R1", "valid after late reset", 32'(eoc_valid), 32'd0);
    chk("R1", "loss after late reset", 32'(loss_count), 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule